// File: doc/BRIEF.md
# Third-Order Dithered Sigma-Delta Modulator

This block is the noise-shaping core of an oversampled digital-to-analog path. Each time the upstream interpolator presents a sample with its valid strobe, the block adds a small pseudo-random offset, quantizes the result to one of 32 levels, and feeds the quantization error back so that the noise spectrum is shaped by (1 - z^-1)^3. Most of the noise is pushed out of the signal band, and the dither breaks up the idle tones a plain loop would produce on quiet or constant inputs.

The loop is built in error-feedback form. Three registers hold the last three quantization errors, and the quantizer input is the sample plus dither plus 3·e[n-1] - 3·e[n-2] + e[n-3]. Loop state and the dither generator advance only on strobes, so the block runs at whatever oversampled rate the strobe sets (128 or 256 times the base rate). The output code is offset binary and appears one clock after its strobe, with its own valid.

Top module: `dsm3_dither`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_code` is 16, all three error registers are zero and the dither generator holds the seed value 1.
- R2: `out_valid` is high for exactly the one cycle that follows each cycle with `in_valid` high. `out_code` changes only in that cycle and holds its value otherwise.
- R3: The quantizer takes the 32-bit loop value v and gives q = floor(v / 2^19), clamped to the range -16..15. The output is `out_code` = q + 16, so code 0 is the most negative level and 31 the most positive. The level it stands for is y = (code - 16)·2^19 + 2^18.
- R4: v = sample + dither + 3·e1 - 3·e2 + e3 is formed at full precision and then saturated to 32-bit signed. The new error e = v - y is also saturated to 32 bits, and the error history then shifts (e3 <= e2, e2 <= e1, e1 <= e).
- R5: With dither disabled, the sequence of output codes matches a bit-exact model of R3 and R4 for any sequence of 24-bit two's-complement inputs.
- R6: The dither generator is a 35-bit shift register. Each strobe it shifts left by one bit and inserts bit34 XOR bit32 at bit 0, which gives a period of 2^35 - 1. It steps on every strobe, whether dither is enabled or not.
- R7: On a strobe with `dither_en` high, the dither is bits 3..0 of the generator read as a 4-bit signed value and multiplied by 2^14, taken before that strobe's step. With `dither_en` low, the dither is zero.
- R8: For a constant input held over 2048 strobes, the mean of the reconstructed levels y lies within 2^15 of the input, both with and without dither.
- R9: Whenever the code is neither 0 nor 31, the error just stored lies in [-2^18, 2^18).
- R10: In cycles with `in_valid` low, the values on `in_sample` and `dither_en` are ignored and neither the error registers nor the dither generator change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, one per oversampled period |
| in_sample | input | 24 | Signed two's-complement input sample |
| dither_en | input | 1 | Enables the dither contribution |
| out_valid | output | 1 | High for one cycle when a new code is present |
| out_code | output | 5 | Offset-binary quantized code |

## Verification
The hardest state to reach is overload. With all three error registers saturated against their 32-bit limits, the quantizer is pinned at a rail, and a correct loop input needs both saturation stages to clamp in the right order. The stimulus reaches this state by holding a full-scale positive input and then a full-scale negative input for tens of strobes, so the unstable third-order loop drives its errors into the limits. A bit-exact model follows every code through this stretch. Idle gaps carrying garbage data and a toggling dither enable run between strobes in every phase, which shows the loop state does not move between strobes.

// File: rtl/dsm3_dither.sv
`timescale 1ns/1ps
module dsm3_dither #(
  parameter int IN_W       = 24,
  parameter int ACC_W      = 32,
  parameter int Q_W        = 5,
  parameter int LFSR_W     = 35,
  parameter int LFSR_TAP   = 33,
  parameter int DITH_W     = 4,
  parameter int DITH_SHIFT = 14,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic                    dither_en,
  output logic                    out_valid,
  output logic [Q_W-1:0]          out_code
);
  localparam int SUM_W   = ACC_W + 4;
  localparam int STEP_SH = IN_W - Q_W;
  localparam int LEVELS  = 2 ** Q_W;
  localparam int MID     = LEVELS / 2;

  localparam logic signed [SUM_W-1:0] SUM_MAX = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SUM_MIN = ~SUM_MAX;
  localparam logic signed [ACC_W-1:0] Q_HI    = ACC_W'(MID - 1);
  localparam logic signed [ACC_W-1:0] Q_LO    = -ACC_W'(MID);
  localparam logic signed [ACC_W-1:0] HALF_Q  = ACC_W'(1) <<< (STEP_SH - 1);

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [SUM_W-1:0] x);
    if (x > SUM_MAX)      return SUM_MAX[ACC_W-1:0];
    else if (x < SUM_MIN) return SUM_MIN[ACC_W-1:0];
    else                  return x[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] err1, err2, err3;
  logic [LFSR_W-1:0]       lfsr_q;

  logic signed [SUM_W-1:0] u_x, d_x, e1_x, e2_x, e3_x, loop_sum;
  logic signed [ACC_W-1:0] v, q_raw, q_clip, y_rec, err_new;
  logic [Q_W-1:0]          code_n;

  assign u_x  = SUM_W'(in_sample);
  assign d_x  = dither_en ? (SUM_W'($signed(lfsr_q[DITH_W-1:0])) <<< DITH_SHIFT) : '0;
  assign e1_x = SUM_W'(err1);
  assign e2_x = SUM_W'(err2);
  assign e3_x = SUM_W'(err3);

  assign loop_sum = u_x + d_x + (e1_x <<< 1) + e1_x - (e2_x <<< 1) - e2_x + e3_x;
  assign v        = sat(loop_sum);

  assign q_raw  = v >>> STEP_SH;
  assign q_clip = (q_raw > Q_HI) ? Q_HI : ((q_raw < Q_LO) ? Q_LO : q_raw);
  assign code_n = Q_W'(q_clip + ACC_W'(MID));

  assign y_rec   = ((ACC_W'(code_n) - ACC_W'(MID)) <<< STEP_SH) + HALF_Q;
  assign err_new = sat(SUM_W'(v) - SUM_W'(y_rec));

  always_ff @(posedge clk) begin
    if (rst) begin
      err1      <= '0;
      err2      <= '0;
      err3      <= '0;
      lfsr_q    <= LFSR_SEED;
      out_valid <= 1'b0;
      out_code  <= Q_W'(MID);
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        err3     <= err2;
        err2     <= err1;
        err1     <= err_new;
        lfsr_q   <= {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP-1]};
        out_code <= code_n;
      end
    end
  end
endmodule

module dsm3_dither_chk #(
  parameter int IN_W   = 24,
  parameter int ACC_W  = 32,
  parameter int Q_W    = 5,
  parameter int LFSR_W = 35
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [Q_W-1:0]          out_code,
  input logic [LFSR_W-1:0]       lfsr_q,
  input logic signed [ACC_W-1:0] err1
);
  localparam int STEP_SH = IN_W - Q_W;
  localparam logic signed [ACC_W-1:0] HALF_Q = ACC_W'(1) <<< (STEP_SH - 1);
  localparam logic [Q_W-1:0] TOP = {Q_W{1'b1}};
  localparam logic [Q_W-1:0] MIDC = {1'b1, {(Q_W-1){1'b0}}};

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_code == MIDC));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_code)));

  p_lfsr_alive_r6: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  p_state_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(lfsr_q) && $stable(err1)));

  p_err_bounded_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_code != '0 && out_code != TOP) |-> (err1 >= -HALF_Q && err1 < HALF_Q));
endmodule

bind dsm3_dither dsm3_dither_chk #(
  .IN_W(IN_W), .ACC_W(ACC_W), .Q_W(Q_W), .LFSR_W(LFSR_W)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_code(out_code), .lfsr_q(lfsr_q), .err1(err1)
);

// File: tb/test_dsm3_dither.sv
`timescale 1ns/1ps
module test_dsm3_dither;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [23:0] in_sample = '0;
  logic dither_en = 1'b0;
  logic out_valid;
  logic [4:0] out_code;

  dsm3_dither i_dsm3_dither (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .dither_en(dither_en), .out_valid(out_valid), .out_code(out_code)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  bit    acc_q[$];
  longint dc_sum = 0;
  int     dc_n = 0;

  longint me1, me2, me3;
  logic [34:0] mlfsr;

  function automatic longint sat32(longint x);
    if (x > 64'sd2147483647)  return 64'sd2147483647;
    if (x < -64'sd2147483648) return -64'sd2147483648;
    return x;
  endfunction

  function automatic longint level_of(int code);
    return longint'(code - 16) * 524288 + 262144;
  endfunction

  function automatic int model_step(longint u, bit den);
    longint d, v, q, y;
    int code;
    d = den ? longint'($signed(mlfsr[3:0])) * 16384 : 0;
    v = sat32(u + d + 3 * me1 - 3 * me2 + me3);
    q = v >>> 19;
    if (q > 15) q = 15;
    if (q < -16) q = -16;
    code = int'(q) + 16;
    y = level_of(code);
    me3 = me2;
    me2 = me1;
    me1 = sat32(v - y);
    mlfsr = {mlfsr[33:0], mlfsr[34] ^ mlfsr[32]};
    return code;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    me1 = 0; me2 = 0; me3 = 0; mlfsr = 35'd1;
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_code after reset", longint'(out_code), 16);
    rst = 1'b0;
  endtask

  task automatic send(longint u, bit den, bit acc, int gap, string tag);
    in_valid  = 1'b1;
    in_sample = u[23:0];
    dither_en = den;
    exp_q.push_back(model_step(u, den));
    tag_q.push_back(tag);
    acc_q.push_back(acc);
    @(negedge clk);
    in_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      in_sample = 24'($urandom);
      dither_en = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check("R2 every strobe produced a code", longint'(exp_q.size()), 0);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", 1, 0);
      end else begin
        int e;
        string t;
        bit a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = acc_q.pop_front();
        check(t, longint'(out_code), longint'(e));
        if (a) begin
          dc_sum += level_of(int'(out_code));
          dc_n++;
        end
      end
    end
  end

  task automatic dc_check(longint u, bit den, string tag);
    longint mean, diff;
    dc_sum = 0;
    dc_n = 0;
    for (int i = 0; i < 2048; i++) send(u, den, 1'b1, 0, "R5 DC code");
    drain();
    mean = dc_sum / 2048;
    diff = mean - u;
    if (diff < 0) diff = -diff;
    check({tag, " mean within 2^15"}, longint'(diff < 32768), 1);
  endtask

  initial begin
    me1 = 0; me2 = 0; me3 = 0; mlfsr = 35'd1;
    do_reset();

    for (int i = 0; i < 64; i++) send(0, 1'b0, 1'b0, 0, "R3 zero input code");
    drain();

    for (int i = 0; i < 300; i++)
      send(-6000000 + (longint'(i) * 97531) % 12000000, 1'b0, 1'b0, i % 3, "R5 R10 ramp no dither");
    drain();

    for (int i = 0; i < 300; i++)
      send(5000000 - (longint'(i) * 123457) % 11000000, 1'b1, 1'b0, (i % 4 == 1) ? 2 : 0, "R6 R7 ramp dither");
    drain();

    for (int i = 0; i < 200; i++)
      send(longint'($signed(24'($urandom))) / 2, 1'($urandom), 1'b0, int'($urandom % 3), "R7 R10 mixed");
    drain();

    for (int i = 0; i < 60; i++) send(8388607, 1'b0, 1'b0, 0, "R4 overload positive");
    for (int i = 0; i < 60; i++) send(-8388608, 1'b1, 1'b0, 1, "R4 overload negative");
    for (int i = 0; i < 40; i++) send(0, 1'b0, 1'b0, 0, "R4 after overload");
    drain();

    do_reset();
    dc_check(3000000, 1'b1, "R8 dithered DC");
    do_reset();
    dc_check(-1234567, 1'b0, "R8 plain DC");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule